// File: doc/BRIEF.md
# Vector Shift-Right-Narrow Datapath

This block executes one vector instruction: an unsigned right shift by an immediate, followed by narrowing. It receives a 32-bit instruction word and a source vector of `VL` bits. `VL` defaults to 128 and must be a multiple of 64. The source vector is split into double-width elements. Each element is shifted right logically, filling with zeros. The low half of each shifted value goes into the even-numbered half-width lane of the result, and every odd-numbered lane is cleared. All lanes are written, because the operation has no mask.

One packed immediate sets both the element size and the shift amount. Three size bits pick the narrow width. The same three bits, joined with a further three immediate bits, are subtracted from twice the narrow width to give a shift from 1 up to the narrow width. If the word is not this instruction, or if the size code is reserved, the block flags it as undefined. The result and the two register indices are captured in one output register, which loads only when `valid_i` is high.

Top module: `vnarrow_shift`

## Requirements
- R1: The word is recognised only when bits 31:24 are 0x45, bit 23 is 0, bit 21 is 1 and bits 15:10 are 000100. Any other word sets `undef_o` to 1 and `res_o` to all zeros.
- R2: The size code is {bit 22, bits 20:19}. Size code 000 sets `undef_o` to 1 and `res_o` to zero, even when the opcode bits match.
- R3: Size code 001 selects 8-bit narrow lanes over 16-bit source elements. The shift is 16 minus the 6-bit value {size code, bits 18:16}, which gives 1 to 8.
- R4: Size codes 010 and 011 select 16-bit narrow lanes over 32-bit source elements. The shift is 32 minus {size code, bits 18:16}, which gives 1 to 16.
- R5: Size codes 100 to 111 select 32-bit narrow lanes over 64-bit source elements. The shift is 64 minus {size code, bits 18:16}, which gives 1 to 32.
- R6: For every source element e, result lane 2e+1 (narrow width) is all zeros.
- R7: The shift is logical and treats the source as unsigned: bits shifted in at the top are zeros, even when the element's top bit is set.
- R8: Result lane 2e receives only the low narrow-width bits of the shifted element e. Higher bits are dropped.
- R9: `rd_o` is taken from bits 4:0 and `rn_o` from bits 9:5 of the word accepted with `valid_i`. This holds for legal and undefined words alike.
- R10: When `valid_i` is low, all outputs keep their values whatever the other inputs do.
- R11: Synchronous reset clears `res_o`, `rd_o`, `rn_o` and `undef_o` to zero.
- R12: Outputs reflect an accepted word after exactly one rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Accept strobe for the instruction and source |
| instr_i | input | 32 | Instruction word |
| src_i | input | VL | Source vector |
| res_o | output | VL | Registered narrowed result |
| rd_o | output | 5 | Registered destination register index |
| rn_o | output | 5 | Registered source register index |
| undef_o | output | 1 | Registered undefined-instruction flag |

## Verification
Random source data rarely reaches the ends of the shift range. For each width, the extremes are immediates of all ones (shift 1) and the lowest immediate of that size code (full-width shift). The stimulus therefore builds instruction words from an explicit size code and immediate, and sends both extremes at every width. It pairs them with all-ones sources, so that truncation and zero fill are both visible in one result. Words that differ from a legal word in a single opcode bit, and a word with reserved size code 000, cover the undefined path.

// File: rtl/vns_pkg.sv
package vns_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned SHAMT_W = 6;

  localparam logic [7:0] OPC_HI  = 8'h45;
  localparam logic [5:0] OPC_MID = 6'b000100;

  typedef enum logic [1:0] {
    NW_NONE = 2'd0,
    NW_8    = 2'd1,
    NW_16   = 2'd2,
    NW_32   = 2'd3
  } nw_e;

  typedef struct packed {
    logic               legal;
    nw_e                size;
    logic [SHAMT_W-1:0] shamt;
    logic [REG_W-1:0]   rn;
    logic [REG_W-1:0]   rd;
  } dec_t;

endpackage

// File: rtl/vns_decode.sv
module vns_decode
  import vns_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic       opc_ok;
  logic [2:0] szc;
  logic [2:0] imm;
  logic [5:0] packed_imm;
  logic [6:0] sub8, sub16, sub32;

  assign opc_ok = (instr[31:24] == OPC_HI) && !instr[23] && instr[21]
                  && (instr[15:10] == OPC_MID);
  assign szc        = {instr[22], instr[20:19]};
  assign imm        = instr[18:16];
  assign packed_imm = {szc, imm};

  assign sub8  = 7'd16 - {1'b0, packed_imm};
  assign sub16 = 7'd32 - {1'b0, packed_imm};
  assign sub32 = 7'd64 - {1'b0, packed_imm};

  always_comb begin
    dec.rd    = instr[4:0];
    dec.rn    = instr[9:5];
    dec.size  = NW_NONE;
    dec.shamt = '0;
    if (szc[2]) begin
      dec.size  = NW_32;
      dec.shamt = sub32[SHAMT_W-1:0];
    end else if (szc[1]) begin
      dec.size  = NW_16;
      dec.shamt = sub16[SHAMT_W-1:0];
    end else if (szc[0]) begin
      dec.size  = NW_8;
      dec.shamt = sub8[SHAMT_W-1:0];
    end
    dec.legal = opc_ok && (dec.size != NW_NONE);
  end

endmodule

// File: rtl/vns_lane.sv
module vns_lane
  import vns_pkg::*;
#(
  parameter int unsigned NW = 8
) (
  input  logic [2*NW-1:0]    src,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [2*NW-1:0]    dst
);

  logic [2*NW-1:0] shifted;

  assign shifted = src >> shamt;
  assign dst     = {{NW{1'b0}}, NW'(shifted)};

endmodule

// File: rtl/vns_bank.sv
module vns_bank
  import vns_pkg::*;
#(
  parameter int unsigned VL = 128,
  parameter int unsigned NW = 8
) (
  input  logic [VL-1:0]      src,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [VL-1:0]      dst
);

  localparam int unsigned EW    = 2 * NW;
  localparam int unsigned ELEMS = VL / EW;

  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    vns_lane #(.NW(NW)) u_lane (
      .src   (src[e*EW +: EW]),
      .shamt (shamt),
      .dst   (dst[e*EW +: EW])
    );
  end

endmodule

// File: rtl/vnarrow_shift.sv
module vnarrow_shift
  import vns_pkg::*;
#(
  parameter int unsigned VL = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [VL-1:0]       src_i,
  output logic [VL-1:0]       res_o,
  output logic [REG_W-1:0]    rd_o,
  output logic [REG_W-1:0]    rn_o,
  output logic                undef_o
);

  localparam int unsigned NUM_SZ = 3;

  dec_t          dec;
  logic [VL-1:0] bank_res [NUM_SZ];
  logic [VL-1:0] res_d;

  vns_decode u_dec (
    .instr (instr_i),
    .dec   (dec)
  );

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_bank
    vns_bank #(.VL(VL), .NW(8 << g)) u_bank (
      .src   (src_i),
      .shamt (dec.shamt),
      .dst   (bank_res[g])
    );
  end

  always_comb begin
    res_d = '0;
    if (dec.legal) begin
      unique case (dec.size)
        NW_8:    res_d = bank_res[0];
        NW_16:   res_d = bank_res[1];
        NW_32:   res_d = bank_res[2];
        default: res_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      rd_o    <= '0;
      rn_o    <= '0;
      undef_o <= 1'b0;
    end else if (valid_i) begin
      res_o   <= res_d;
      rd_o    <= dec.rd;
      rn_o    <= dec.rn;
      undef_o <= !dec.legal;
    end
  end

endmodule

// File: rtl/vns_chk.sv
module vns_chk #(
  parameter int unsigned VL = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic [31:0]   instr_i,
  input logic [VL-1:0] res_o,
  input logic [4:0]    rd_o,
  input logic [4:0]    rn_o,
  input logic          undef_o
);

  function automatic logic [VL-1:0] odd_mask(input int unsigned nw);
    logic [VL-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < VL; b++)
      if (((b / nw) % 2) == 1) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [VL-1:0] ODD8  = odd_mask(8);
  localparam logic [VL-1:0] ODD16 = odd_mask(16);
  localparam logic [VL-1:0] ODD32 = odd_mask(32);

  logic       opm;
  logic [2:0] szc;
  logic       rst_d;

  assign opm = (instr_i[31:24] == 8'h45) && !instr_i[23] && instr_i[21]
               && (instr_i[15:10] == 6'b000100);
  assign szc = {instr_i[22], instr_i[20:19]};

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_CLEAR: assert (res_o == '0 && rd_o == '0 && rn_o == '0 && !undef_o); // R11
    end
  end

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst) undef_o |-> res_o == '0); // R1
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst) valid_i && !opm |=> undef_o); // R1
  AST_SIZE_RESERVED: assert property (@(posedge clk) disable iff (rst) valid_i && szc == 3'b000 |=> undef_o); // R2
  AST_ODD_ZERO_8: assert property (@(posedge clk) disable iff (rst) valid_i && opm && szc == 3'b001 |=> (res_o & ODD8) == '0); // R6
  AST_ODD_ZERO_16: assert property (@(posedge clk) disable iff (rst) valid_i && opm && szc[2:1] == 2'b01 |=> (res_o & ODD16) == '0); // R6
  AST_ODD_ZERO_32: assert property (@(posedge clk) disable iff (rst) valid_i && opm && szc[2] |=> (res_o & ODD32) == '0); // R6
  AST_REG_INDEX: assert property (@(posedge clk) disable iff (rst) valid_i |=> rd_o == $past(instr_i[4:0]) && rn_o == $past(instr_i[9:5])); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !valid_i |=> $stable(res_o) && $stable(undef_o) && $stable(rd_o) && $stable(rn_o)); // R10

endmodule

bind vnarrow_shift vns_chk #(.VL(VL)) u_vns_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .instr_i (instr_i),
  .res_o   (res_o),
  .rd_o    (rd_o),
  .rn_o    (rn_o),
  .undef_o (undef_o)
);

// File: tb/test_vnarrow_shift.sv
module test_vnarrow_shift;

  localparam int unsigned VL     = 128;
  localparam time         PERIOD = 10ns;

  typedef struct {
    logic [VL-1:0] res;
    logic          undef;
    logic [4:0]    rd;
    logic [4:0]    rn;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VL-1:0] src = '0;
  logic [VL-1:0] res;
  logic [4:0]    rd, rn;
  logic          undef;

  int checks = 0;
  int errors = 0;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  vnarrow_shift #(.VL(VL)) i_vnarrow_shift (
    .clk(clk), .rst(rst), .valid_i(valid), .instr_i(instr), .src_i(src),
    .res_o(res), .rd_o(rd), .rn_o(rn), .undef_o(undef)
  );

  function automatic logic [31:0] mk(input logic [2:0] szc, input logic [2:0] imm,
                                     input logic [4:0] n, input logic [4:0] d);
    return {8'h45, 1'b0, szc[2], 1'b1, szc[1:0], imm, 6'b000100, n, d};
  endfunction

  function automatic logic [VL-1:0] model(input logic [31:0] w, input logic [VL-1:0] s,
                                          output logic bad);
    logic [VL-1:0] r;
    logic [2:0]    szc;
    logic [63:0]   el;
    int            nw, sh;
    r   = '0;
    szc = {w[22], w[20:19]};
    bad = !(w[31:24] == 8'h45 && !w[23] && w[21] && w[15:10] == 6'b000100) || szc == 3'b000;
    if (bad) return r;
    nw = szc[2] ? 32 : (szc[1] ? 16 : 8);
    sh = 2 * nw - int'({szc, w[18:16]});
    for (int e = 0; e < VL / (2 * nw); e++) begin
      el = '0;
      for (int b = 0; b < 2 * nw; b++) el[b] = s[e*2*nw + b];
      el = el >> sh;
      for (int b = 0; b < nw; b++) r[2*e*nw + b] = el[b];
    end
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [VL-1:0] s, input string tag);
    item_t it;
    logic  b;
    @(negedge clk);
    instr = w;
    src   = s;
    valid = 1'b1;
    it.res   = model(w, s, b);
    it.undef = b;
    it.rd    = w[4:0];
    it.rn    = w[9:5];
    it.tag   = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0;
  endtask

  function automatic logic [VL-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Monitor: compares the registered outputs one edge after each accept (R12)
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && valid) begin
        item_t it;
        @(negedge clk);
        it = q.pop_front();
        check(it.tag, "res",   res,        it.res);
        check(it.tag, "undef", VL'(undef), VL'(it.undef));
        check(it.tag, "rd",    VL'(rd),    VL'(it.rd));
        check(it.tag, "rn",    VL'(rn),    VL'(it.rn));
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [VL-1:0] ones;
    logic [VL-1:0] prev;
    ones = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R11", "res",   res,        '0);
    check("R11", "undef", VL'(undef), '0);
    check("R11", "rd",    VL'(rd),    '0);
    check("R11", "rn",    VL'(rn),    '0);

    // 8-bit narrow: minimum and maximum shifts
    send(mk(3'b001, 3'b111, 5'd3, 5'd7),  ones,  "R3_shift1_R7_R8");
    send(mk(3'b001, 3'b000, 5'd4, 5'd8),  ones,  "R3_shift8_R6");
    send(mk(3'b001, 3'b011, 5'd1, 5'd2),  rnd(), "R3_rand");
    // 16-bit narrow
    send(mk(3'b010, 3'b000, 5'd5, 5'd9),  ones,  "R4_shift16_R6");
    send(mk(3'b011, 3'b111, 5'd6, 5'd10), ones,  "R4_shift1_R7_R8");
    send(mk(3'b010, 3'b101, 5'd11, 5'd12), rnd(), "R4_rand");
    // 32-bit narrow
    send(mk(3'b100, 3'b000, 5'd13, 5'd14), ones, "R5_shift32_R6");
    send(mk(3'b111, 3'b111, 5'd15, 5'd16), ones, "R5_shift1_R7_R8");
    send(mk(3'b101, 3'b010, 5'd17, 5'd18), rnd(), "R5_rand");
    // Undefined words
    send(mk(3'b000, 3'b101, 5'd19, 5'd20), ones, "R2_size000");
    send(mk(3'b001, 3'b000, 5'd21, 5'd22) ^ 32'h0080_0000, ones, "R1_bit23");
    send(mk(3'b100, 3'b000, 5'd23, 5'd24) ^ 32'h0000_0400, ones, "R1_bit10");
    send(mk(3'b010, 3'b000, 5'd25, 5'd26) ^ 32'h0100_0000, ones, "R1_bit24");
    for (int k = 0; k < 24; k++) begin
      logic [2:0] sz;
      sz = 3'($urandom_range(1, 7));
      send(mk(sz, 3'($urandom), 5'($urandom), 5'($urandom)), rnd(), "R9_rand_R6");
    end
    send(mk(3'b011, 3'b010, 5'd30, 5'd31), ones, "R4_last");
    idle();
    wait (q.size() == 0);
    @(negedge clk);

    // R10: idle cycles with changing inputs leave outputs unchanged
    prev  = res;
    instr = mk(3'b001, 3'b111, 5'd1, 5'd1);
    src   = rnd();
    repeat (3) @(negedge clk);
    check("R10", "res",   res,        prev);
    check("R10", "rd",    VL'(rd),    VL'(5'd31));
    check("R10", "undef", VL'(undef), '0);

    // R12: not visible before the rising edge
    send(mk(3'b100, 3'b000, 5'd2, 5'd3), ones, "R12_after_edge");
    #(PERIOD/4);
    check("R12", "res_before_edge", res, prev);
    idle();
    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end

endmodule